// File: doc/BRIEF.md
# Overcharge Delay and Release Controller

This block sits behind a set of per-cell overvoltage comparators in a battery pack protector. For up to three series cells it receives two flags per cell. One says the cell is above its detection threshold. The other says the cell is above its release threshold, which is the detection level minus the hysteresis. From these flags it drives a single charge-control level that an external drive stage uses to switch off the charge FET. All timing runs on an internal millisecond tick derived from the system clock.

Any one cell that goes over the detection threshold starts a detection delay. The output changes only when that delay has run out. A brief dip of the overvoltage condition, such as charger ripple, pauses the delay count but does not clear it. Only a dip that lasts as long as a separate filter time throws the accumulated count away. Once the block is overcharged, it returns to normal only after every cell has stayed below its release threshold for the whole release delay. A test input replaces the long detection delay with a short one, so that production test takes less time. The output polarity can be selected, and a one-cycle marker pulse shows each entry into and exit from the overcharged condition.

Top module: `chg_guard_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high and in the first cycle after it, the controller is in its normal state, `ovc_edge_o` is 0 and `chg_ctrl_o` is at its inactive level.
- R2: `chg_ctrl_o` equals the internal overcharged condition XOR `act_low_i`. In the normal state it is therefore 0 with `act_low_i`=0 and 1 with `act_low_i`=1. The condition is active while overcharged and while release counting.
- R3: The detection flags are ORed across cells. Any single bit of `cell_over_det_i` starts the detection count, whatever the other bits are.
- R4: The detection delay is selected by `det_sel_i`: 0 gives 1 s, 1 gives 2 s, 2 gives 4 s, 3 gives 6 s, and 4 to 7 all give 8 s. One second is SEC_TICKS ticks. The output goes active on the tick that completes the delay, counted only while detection is present.
- R5: If detection drops out for fewer than FILT_TICKS ticks, the accumulated detection count is held. When detection returns, counting resumes from that value.
- R6: If detection stays absent for FILT_TICKS ticks, the detection count is cleared. A later detection counts the full delay again from zero.
- R7: A cell counts as high for release when either of its flags is set. Release needs every cell low continuously for the release delay. `rel_sel_i`=0 selects REL_SHORT_TICKS (2 ms) and `rel_sel_i`=1 selects REL_LONG_TICKS (64 ms). Any cell going high during the release count returns the block to overcharged, and the count restarts.
- R8: While `test_short_i` is 1, the detection delay is TEST_TICKS ticks whatever `det_sel_i` is. The filter time and the release delay are not shortened.
- R9: `ovc_edge_o` is high for exactly one cycle, the first cycle in which `chg_ctrl_o` shows a new overcharged condition. It is low at all other times.
- R10: The cell flags pass through two flops before use. A tick occurs every TICK_DIV cycles, the first one TICK_DIV cycles after reset is released. Entry and exit delays therefore lie between (N-1)*TICK_DIV+4 and N*TICK_DIV+3 cycles of a flag change made between clock edges, where N is the delay in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_over_det_i | input | NUM_CELLS | Per-cell flag: above detection threshold (asynchronous) |
| cell_over_rel_i | input | NUM_CELLS | Per-cell flag: above release threshold (asynchronous) |
| det_sel_i | input | 3 | Detection delay select |
| rel_sel_i | input | 1 | Release delay select |
| test_short_i | input | 1 | Shortened detection delay for test |
| act_low_i | input | 1 | Output polarity: 1 selects active-low |
| chg_ctrl_o | output | 1 | Charge-control level |
| ovc_edge_o | output | 1 | One-cycle marker of entry into or exit from overcharge |

## Verification
The bench targets dropouts just shorter and just longer than the filter time. A design that restarted on every dip would assert about 60 ticks late after a short dip. A design that never cleared would assert early after a long gap. Release is interrupted by a brief high on one cell. A controller that only paused the release count would exit too soon. Test mode is combined with the longest delay select and the long release setting, which exposes a design that also shortened the release delay. Long random runs that change polarity, selects and flags cross-check every cycle, including the edge pulse, which would be missed if it were generated from the wrong register stage.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL           = 3'd0,
        ST_DETECT_COUNTING  = 3'd1,
        ST_DROPOUT_FILTER   = 3'd2,
        ST_OVERCHARGED      = 3'd3,
        ST_RELEASE_COUNTING = 3'd4
    } ocp_state_e;

    // Seconds of detection delay for a select code; codes above 4 map to the longest delay.
    function automatic int unsigned det_seconds(input logic [2:0] sel);
        case (sel)
            3'd0:    det_seconds = 1;
            3'd1:    det_seconds = 2;
            3'd2:    det_seconds = 4;
            3'd3:    det_seconds = 6;
            default: det_seconds = 8;
        endcase
    endfunction

    function automatic logic is_overcharged(input ocp_state_e st);
        is_overcharged = (st == ST_OVERCHARGED) || (st == ST_RELEASE_COUNTING);
    endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1_d, s1_q, s2_d, s2_q;

        always_comb begin
            s1_d = d_i[b];
            s2_d = s1_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= s1_d;
                s2_q <= s2_d;
            end
        end

        assign q_o[b] = s2_q;
    end
endmodule

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;
    logic          wrap;

    always_comb begin
        wrap  = (cnt_q == LAST);
        cnt_d = wrap ? '0 : cnt_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign tick_o = wrap;
endmodule

// File: rtl/ocp_fsm.sv
module ocp_fsm
    import ocp_pkg::*;
#(
    parameter int SEC_TICKS       = 1000,
    parameter int TEST_TICKS      = 32,
    parameter int FILT_TICKS      = 12,
    parameter int REL_SHORT_TICKS = 2,
    parameter int REL_LONG_TICKS  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       any_det_i,
    input  logic       any_high_i,
    input  logic [2:0] det_sel_i,
    input  logic       rel_sel_i,
    input  logic       test_short_i,
    output ocp_state_e state_o,
    output logic       ovc_o,
    output logic       pulse_o
);
    localparam int DET_MAX = 8 * SEC_TICKS;
    localparam int CW      = $clog2(DET_MAX + 1);
    localparam int FW      = $clog2(FILT_TICKS + 1);
    localparam int REL_MAX = (REL_LONG_TICKS > REL_SHORT_TICKS) ? REL_LONG_TICKS : REL_SHORT_TICKS;
    localparam int RW      = $clog2(REL_MAX + 1);

    typedef struct packed {
        ocp_state_e    st;
        logic [CW-1:0] det_cnt;
        logic [FW-1:0] filt_cnt;
        logic [RW-1:0] rel_cnt;
        logic          pulse;
    } regs_t;

    regs_t         r_d, r_q;
    logic [CW:0]   det_lim, det_next;
    logic [FW:0]   filt_next;
    logic [RW:0]   rel_lim, rel_next;

    always_comb begin
        det_lim   = test_short_i ? (CW+1)'(TEST_TICKS)
                                 : (CW+1)'(det_seconds(det_sel_i) * SEC_TICKS);
        rel_lim   = rel_sel_i ? (RW+1)'(REL_LONG_TICKS) : (RW+1)'(REL_SHORT_TICKS);
        det_next  = {1'b0, r_q.det_cnt} + (CW+1)'(1);
        filt_next = {1'b0, r_q.filt_cnt} + (FW+1)'(1);
        rel_next  = {1'b0, r_q.rel_cnt} + (RW+1)'(1);

        r_d = r_q;
        unique case (r_q.st)
            ST_NORMAL: begin
                if (any_det_i) begin
                    r_d.st      = ST_DETECT_COUNTING;
                    r_d.det_cnt = '0;
                end
            end
            ST_DETECT_COUNTING: begin
                if (!any_det_i) begin
                    r_d.st       = ST_DROPOUT_FILTER;
                    r_d.filt_cnt = '0;
                end else if (tick_i) begin
                    if (det_next >= det_lim) begin
                        r_d.st      = ST_OVERCHARGED;
                        r_d.det_cnt = '0;
                    end else begin
                        r_d.det_cnt = det_next[CW-1:0];
                    end
                end
            end
            ST_DROPOUT_FILTER: begin
                if (any_det_i) begin
                    r_d.st = ST_DETECT_COUNTING;
                end else if (tick_i) begin
                    if (filt_next >= (FW+1)'(FILT_TICKS)) begin
                        r_d.st       = ST_NORMAL;
                        r_d.det_cnt  = '0;
                        r_d.filt_cnt = '0;
                    end else begin
                        r_d.filt_cnt = filt_next[FW-1:0];
                    end
                end
            end
            ST_OVERCHARGED: begin
                if (!any_high_i) begin
                    r_d.st      = ST_RELEASE_COUNTING;
                    r_d.rel_cnt = '0;
                end
            end
            ST_RELEASE_COUNTING: begin
                if (any_high_i) begin
                    r_d.st      = ST_OVERCHARGED;
                    r_d.rel_cnt = '0;
                end else if (tick_i) begin
                    if (rel_next >= rel_lim) begin
                        r_d.st      = ST_NORMAL;
                        r_d.rel_cnt = '0;
                    end else begin
                        r_d.rel_cnt = rel_next[RW-1:0];
                    end
                end
            end
            default: begin
                r_d.st = ST_NORMAL;
            end
        endcase
        r_d.pulse = is_overcharged(r_d.st) != is_overcharged(r_q.st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st       <= ST_NORMAL;
            r_q.det_cnt  <= '0;
            r_q.filt_cnt <= '0;
            r_q.rel_cnt  <= '0;
            r_q.pulse    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign ovc_o   = is_overcharged(r_q.st);
    assign pulse_o = r_q.pulse;
endmodule

// File: rtl/chg_guard_ctrl.sv
module chg_guard_ctrl
    import ocp_pkg::*;
#(
    parameter int NUM_CELLS       = 3,
    parameter int TICK_DIV        = 125000,
    parameter int SEC_TICKS       = 1000,
    parameter int TEST_TICKS      = 32,
    parameter int FILT_TICKS      = 12,
    parameter int REL_SHORT_TICKS = 2,
    parameter int REL_LONG_TICKS  = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CELLS-1:0] cell_over_det_i,
    input  logic [NUM_CELLS-1:0] cell_over_rel_i,
    input  logic [2:0]           det_sel_i,
    input  logic                 rel_sel_i,
    input  logic                 test_short_i,
    input  logic                 act_low_i,
    output logic                 chg_ctrl_o,
    output logic                 ovc_edge_o
);
    localparam int SW = 2 * NUM_CELLS;

    logic [SW-1:0]        flags_s;
    logic [NUM_CELLS-1:0] det_s, rel_s;
    logic                 any_det_s, any_high_s, tick;
    logic                 ovc, pulse;
    ocp_state_e           state;

    ocp_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({cell_over_rel_i, cell_over_det_i}),
        .q_o (flags_s)
    );

    assign det_s      = flags_s[NUM_CELLS-1:0];
    assign rel_s      = flags_s[SW-1:NUM_CELLS];
    assign any_det_s  = |det_s;
    assign any_high_s = (|rel_s) | any_det_s;

    ocp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    ocp_fsm #(
        .SEC_TICKS       (SEC_TICKS),
        .TEST_TICKS      (TEST_TICKS),
        .FILT_TICKS      (FILT_TICKS),
        .REL_SHORT_TICKS (REL_SHORT_TICKS),
        .REL_LONG_TICKS  (REL_LONG_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .any_det_i    (any_det_s),
        .any_high_i   (any_high_s),
        .det_sel_i    (det_sel_i),
        .rel_sel_i    (rel_sel_i),
        .test_short_i (test_short_i),
        .state_o      (state),
        .ovc_o        (ovc),
        .pulse_o      (pulse)
    );

    assign chg_ctrl_o = ovc ^ act_low_i;
    assign ovc_edge_o = pulse;
endmodule

// File: rtl/chg_guard_ctrl_chk.sv
module chg_guard_ctrl_chk
    import ocp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       any_det,
    input logic       any_high,
    input ocp_state_e state,
    input logic       ovc,
    input logic       pulse
);
    p_entry_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovc) |-> ($past(state) == ST_DETECT_COUNTING) && $past(tick));

    p_exit_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ovc) |-> ($past(state) == ST_RELEASE_COUNTING) && $past(tick));

    p_release_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RELEASE_COUNTING && any_high) |=> state == ST_OVERCHARGED);

    p_pulse_marks_change_r9: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (ovc != $past(ovc)));

    p_change_has_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (ovc != $past(ovc)) |-> pulse);

    p_dropout_resume_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DROPOUT_FILTER && any_det) |=> state == ST_DETECT_COUNTING);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && !any_det) |=> state == ST_NORMAL);

    p_tick_spacing_r10: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

bind chg_guard_ctrl chg_guard_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .any_det  (any_det_s),
    .any_high (any_high_s),
    .state    (state),
    .ovc      (ovc),
    .pulse    (pulse)
);

// File: tb/chg_guard_ctrl_bench.sv
module chg_guard_ctrl_bench;
    localparam int N    = 3;
    localparam int TDIV = 4;
    localparam int SEC  = 50;
    localparam int TST  = 8;
    localparam int FLT  = 12;
    localparam int RS   = 2;
    localparam int RL   = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] det = '0, high = '0;
    logic [2:0]   det_sel = 3'd0;
    logic         rel_sel = 1'b0, test_mode = 1'b0, act_low = 1'b0;
    logic         chg, edge_p;

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    chg_guard_ctrl #(
        .NUM_CELLS(N), .TICK_DIV(TDIV), .SEC_TICKS(SEC), .TEST_TICKS(TST),
        .FILT_TICKS(FLT), .REL_SHORT_TICKS(RS), .REL_LONG_TICKS(RL)
    ) u_chg_guard_ctrl (
        .clk(clk), .rst(rst), .cell_over_det_i(det), .cell_over_rel_i(high),
        .det_sel_i(det_sel), .rel_sel_i(rel_sel), .test_short_i(test_mode),
        .act_low_i(act_low), .chg_ctrl_o(chg), .ovc_edge_o(edge_p)
    );

    // Requirement-level expectations
    function automatic int det_ticks(input logic [2:0] sel, input logic tm);
        int secs;
        if (tm) return TST;
        case (sel)
            3'd0: secs = 1; 3'd1: secs = 2; 3'd2: secs = 4; 3'd3: secs = 6;
            default: secs = 8;
        endcase
        return secs * SEC;
    endfunction

    function automatic int rel_ticks(input logic rs);
        return rs ? RL : RS;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Timing reference from R3..R10: two-flop capture, tick every TDIV cycles
    logic [N-1:0] m_d1, m_d2, m_h1, m_h2;
    int m_tc, m_st, m_dc, m_fc, m_rc;
    bit m_ovc, m_pulse;

    always @(posedge clk) begin
        bit tk, ad, ah, prev;
        int lim, rlim;
        if (rst) begin
            m_d1 = '0; m_d2 = '0; m_h1 = '0; m_h2 = '0;
            m_tc = 0; m_st = 0; m_dc = 0; m_fc = 0; m_rc = 0;
            m_ovc = 0; m_pulse = 0;
        end else begin
            tk   = (m_tc == TDIV - 1);
            ad   = |m_d2;
            ah   = (|m_h2) | ad;
            lim  = det_ticks(det_sel, test_mode);
            rlim = rel_ticks(rel_sel);
            prev = m_ovc;
            case (m_st)
                0: if (ad) begin m_st = 1; m_dc = 0; end
                1: if (!ad) begin m_st = 2; m_fc = 0; end
                   else if (tk) begin
                       if (m_dc + 1 >= lim) begin m_st = 3; m_dc = 0; end
                       else m_dc++;
                   end
                2: if (ad) m_st = 1;
                   else if (tk) begin
                       if (m_fc + 1 >= FLT) begin m_st = 0; m_dc = 0; m_fc = 0; end
                       else m_fc++;
                   end
                3: if (!ah) begin m_st = 4; m_rc = 0; end
                default: if (ah) begin m_st = 3; m_rc = 0; end
                   else if (tk) begin
                       if (m_rc + 1 >= rlim) begin m_st = 0; m_rc = 0; end
                       else m_rc++;
                   end
            endcase
            m_ovc   = (m_st == 3) || (m_st == 4);
            m_pulse = (m_ovc != prev);
            m_d2 = m_d1; m_d1 = det;
            m_h2 = m_h1; m_h1 = high;
            m_tc = tk ? 0 : m_tc + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(chg === (m_ovc ^ act_low), {tag, "/R2 level"}, int'(chg), int'(m_ovc ^ act_low));
            check(edge_p === m_pulse, {tag, "/R9 pulse"}, int'(edge_p), int'(m_pulse));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts negedges until the active state reaches lvl (polarity act_low = 0 here)
    task automatic wait_ovc(input bit lvl, input int maxc, output int n, output int pulses);
        n = 0; pulses = 0;
        while ((chg ^ act_low) !== lvl && n < maxc) begin
            @(negedge clk); n++;
            if (edge_p) pulses++;
        end
    endtask

    task automatic window(input string req, input int n, input int ticks);
        int lo = (ticks - 1) * TDIV + 4;
        int hi = ticks * TDIV + 3;
        check(n >= lo && n <= hi, req, n, ticks * TDIV);
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int n, p, lim;
        void'($urandom(32'd20240611));

        // R1 / R2: reset state and polarity
        cyc(3);
        check(chg === 1'b0 && edge_p === 1'b0, "R1 reset level", int'(chg), 0);
        act_low = 1'b1; cyc(1);
        check(chg === 1'b1, "R2 active-low idle", int'(chg), 1);
        act_low = 1'b0; cyc(1);
        rst = 1'b0; cyc(1);
        check(chg === 1'b0 && edge_p === 1'b0, "R1 after release", int'(chg), 0);

        // R3 / R4 / R10: single middle cell, 1 s delay
        tag = "R3"; det_sel = 3'd0; det = 3'b010; high = 3'b010;
        wait_ovc(1, 5000, n, p);
        window("R3 R4 entry 1s", n, det_ticks(3'd0, 0));
        check(p == 1, "R9 entry pulses", p, 1);
        tag = "R7"; det = '0; high = '0; rel_sel = 1'b0;
        wait_ovc(0, 5000, n, p);
        window("R7 release short", n, RS);
        check(p == 1, "R9 exit pulses", p, 1);
        cyc(20);

        // R4: select 4 and 7 both give 8 s
        tag = "R4"; det_sel = 3'd7; det = 3'b100; high = 3'b100;
        wait_ovc(1, 5000, n, p);
        window("R4 sel7 is 8s", n, det_ticks(3'd4, 0));
        det = '0; high = '0;
        wait_ovc(0, 5000, n, p);
        cyc(20);

        // R5: short dropout keeps count
        tag = "R5"; det_sel = 3'd1; lim = det_ticks(3'd1, 0);
        det = 3'b001; high = 3'b001;
        cyc(60 * TDIV); det = '0; cyc(5 * TDIV); det = 3'b001;
        wait_ovc(1, 5000, n, p);
        n += 65 * TDIV;
        check(n >= (lim - 1) * TDIV + 5 * TDIV && n <= lim * TDIV + 5 * TDIV + 3 * TDIV,
              "R5 resumed count", n, lim * TDIV + 5 * TDIV);
        det = '0; high = '0;
        wait_ovc(0, 5000, n, p);
        cyc(20);

        // R6: long dropout clears count
        tag = "R6";
        det = 3'b001; high = 3'b001;
        cyc(60 * TDIV); det = '0; cyc(20 * TDIV);
        check(chg === 1'b0, "R6 idle after dropout", int'(chg), 0);
        det = 3'b001;
        wait_ovc(1, 5000, n, p);
        window("R6 full delay again", n, lim);
        det = '0; high = '0;
        wait_ovc(0, 5000, n, p);
        cyc(20);

        // R8: test mode shortens detection only
        tag = "R8"; test_mode = 1'b1; det_sel = 3'd4; rel_sel = 1'b1;
        det = 3'b110; high = 3'b110;
        wait_ovc(1, 5000, n, p);
        window("R8 short detect", n, TST);
        det = '0; high = '0;
        wait_ovc(0, 5000, n, p);
        window("R8 release not shortened", n, RL);
        cyc(20);

        // R7: release interrupted by a brief high cell
        tag = "R7"; test_mode = 1'b0; det_sel = 3'd0; rel_sel = 1'b1;
        det = 3'b001; high = 3'b001;
        wait_ovc(1, 5000, n, p);
        det = '0; high = '0; cyc(30 * TDIV);
        high = 3'b100; cyc(3); high = '0;
        wait_ovc(0, 5000, n, p);
        window("R7 release restarted", n, RL);
        cyc(20);

        // Random mix against the timing reference
        tag = "RND";
        for (int seg = 0; seg < 600; seg++) begin
            int len = 1 + int'($urandom_range(0, 260));
            if ($urandom_range(0, 9) == 0) det_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 9) == 0) rel_sel = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) test_mode = ~test_mode;
            if ($urandom_range(0, 11) == 0) act_low = ~act_low;
            det  = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(1, 7)) : '0;
            high = det | (($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : '0);
            cyc(len);
        end
        finish_run();
    end
endmodule